// File: doc/BRIEF.md
# Nibble-Mode Host Port Register Target

This block sits on the device side of an 8-bit host data port that drives a small network controller. The host has only eight outgoing data lines and four usable incoming status lines. Each byte it writes carries its own meaning. The top three bits are an opcode. Bit 4 tags a nibble as the upper half. The low four bits carry a nibble or part of an address. A strobe qualifies each byte. The block brings that strobe into its own clock domain and treats each rising edge as exactly one event.

There are three opcodes. One latches a register address for writing, one latches an address for reading, and one ends the command. Data nibbles that follow a write address update one half of a byte-wide register in a 16-entry register file. The upper address bit or the nibble's own tag selects which half. While a read address is latched, the selected nibble is shown on status bits 6 to 3. When no address is latched, data nibbles form a bulk stream to the packet buffer. A tagged upper nibble completes the byte and produces a one-cycle commit strobe. Reads of the memory-address slot return packet-buffer data instead of register contents.

Top module: `nibble_port_target`

## Requirements
- R1: After reset, `host_status` is 0, no write or commit strobe fires, and every register reads back as 0.
- R2: Only a rising edge of `host_strobe` makes `host_data` count as a byte. Changes of `host_data` while the strobe stays still have no effect.
- R3: Opcode `010` (bits 7:5) latches a write address from bits 4:0. Each later byte with opcode `000` writes its bits 3:0 into register `addr[3:0]`. The upper half is written when `addr[4]` or byte bit 4 is 1, and the lower half otherwise. Each such write is reported once on the `rf_wr_*` outputs.
- R4: A full-byte write sends the low nibble (bit 4 clear) and then the high nibble (bit 4 set). Afterwards both halves read back as the byte that was sent.
- R5: Opcode `110` latches a read address. While it is latched, `host_status[6:3]` shows the upper nibble of register `addr[3:0]` if `addr[4]`=1, and the lower nibble otherwise. All other status bits are 0.
- R6: Opcode `111` ends the command. The decoder becomes idle, the address is cleared, and `host_status` returns to 0. A later data byte then goes to the bulk stream and not to a register.
- R7: Repeating the same byte has no side effect. A repeated address latch or nibble write leaves the same state. A repeated upper bulk nibble does not commit a second byte.
- R8: When idle, a data byte with bit 4 clear holds the low nibble. A data byte with bit 4 set commits `{upper, held lower}` with a one-cycle `buf_wr_en`, but only if a lower nibble is held.
- R9: A 16-bit word is sent as four nibbles, least significant first, with tags 0,1,0,1. It commits its low byte first and then its high byte.
- R10: A read of register index 14 (the memory-address slot) returns `buf_rd_data`, upper or lower nibble chosen by `addr[4]`.
- R11: Bytes with opcodes `001`, `011`, `100` or `101` change nothing. Data bytes received while a read address is latched write nothing.
- R12: An end-of-command drops a held lower bulk nibble. A following upper nibble then commits nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_data | input | 8 | Host data lines, opcode in bits 7:5 |
| host_strobe | input | 1 | Asynchronous byte qualifier, active on its rising edge |
| buf_rd_data | input | 8 | Packet-buffer byte returned for memory-address reads |
| host_status | output | 8 | Read nibble on bits 6:3, all other bits 0 |
| rf_wr_en | output | 1 | One-cycle register nibble write report |
| rf_wr_idx | output | 4 | Register index written |
| rf_wr_hi | output | 1 | Upper half written |
| rf_wr_nib | output | 4 | Nibble written |
| buf_wr_en | output | 1 | One-cycle bulk byte commit |
| buf_wr_data | output | 8 | Assembled bulk byte |

## Verification
The checker watches several rules on every cycle. Each synchronised event lasts a single cycle, and every register write follows an event while a write address is latched. A commit never lasts longer than one cycle, and the status lines stay at zero whenever no read address is held. Some behaviour only the bench scenarios can show. This includes the correct half being written, full-byte readback, the bulk assembly order for words, the drop of a held nibble at end-of-command, strobe-free data changes being ignored, and memory-address reads steering buffer data.

// File: rtl/npt_pkg.sv
package npt_pkg;
   typedef enum logic [2:0] {
      OPC_DATA  = 3'b000,
      OPC_WADDR = 3'b010,
      OPC_RADDR = 3'b110,
      OPC_END   = 3'b111
   } npt_opc_e;

   typedef enum logic [1:0] {
      DEC_IDLE = 2'd0,
      DEC_WR   = 2'd1,
      DEC_RD   = 2'd2
   } npt_state_e;
endpackage

// File: rtl/npt_strobe_sync.sv
module npt_strobe_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe_async,
   output logic event_pulse
);
   logic [STAGES-1:0] chain_q;
   logic              last_q;

   genvar gi;
   generate
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[gi] <= 1'b0;
               else        chain_q[gi] <= strobe_async;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[gi] <= 1'b0;
               else        chain_q[gi] <= chain_q[gi-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= chain_q[STAGES-1];
   end

   assign event_pulse = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/npt_cmd_decoder.sv
module npt_cmd_decoder
   import npt_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int ADDR_W = 5,
   parameter int NIB_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ev,
   input  logic [BYTE_W-1:0] byte_in,
   output logic              rd_active,
   output logic              wr_active,
   output logic [ADDR_W-1:0] addr_q,
   output logic              rf_we,
   output logic [ADDR_W-2:0] rf_idx,
   output logic              rf_hi,
   output logic [NIB_W-1:0]  rf_nib,
   output logic              bk_valid,
   output logic              bk_hi,
   output logic [NIB_W-1:0]  bk_nib,
   output logic              bk_abort
);
   localparam int OPC_LSB = BYTE_W - 3;
   localparam int TAG_BIT = NIB_W;
   localparam int IDX_W   = ADDR_W - 1;

   npt_state_e state_q;
   npt_opc_e   opc;
   logic       tag;

   assign opc = npt_opc_e'(byte_in[BYTE_W-1:OPC_LSB]);
   assign tag = byte_in[TAG_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= DEC_IDLE;
         addr_q  <= '0;
      end else if (ev) begin
         case (opc)
            OPC_END: begin
               state_q <= DEC_IDLE;
               addr_q  <= '0;
            end
            OPC_WADDR: begin
               state_q <= DEC_WR;
               addr_q  <= byte_in[ADDR_W-1:0];
            end
            OPC_RADDR: begin
               state_q <= DEC_RD;
               addr_q  <= byte_in[ADDR_W-1:0];
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rf_we    <= 1'b0;
         rf_idx   <= '0;
         rf_hi    <= 1'b0;
         rf_nib   <= '0;
         bk_valid <= 1'b0;
         bk_hi    <= 1'b0;
         bk_nib   <= '0;
         bk_abort <= 1'b0;
      end else begin
         rf_we    <= 1'b0;
         bk_valid <= 1'b0;
         bk_abort <= 1'b0;
         if (ev) begin
            if (opc == OPC_END) begin
               bk_abort <= 1'b1;
            end else if (opc == OPC_DATA) begin
               if (state_q == DEC_WR) begin
                  rf_we  <= 1'b1;
                  rf_idx <= addr_q[IDX_W-1:0];
                  rf_hi  <= addr_q[ADDR_W-1] | tag;
                  rf_nib <= byte_in[NIB_W-1:0];
               end else if (state_q == DEC_IDLE) begin
                  bk_valid <= 1'b1;
                  bk_hi    <= tag;
                  bk_nib   <= byte_in[NIB_W-1:0];
               end
            end
         end
      end
   end

   assign rd_active = (state_q == DEC_RD);
   assign wr_active = (state_q == DEC_WR);
endmodule

// File: rtl/npt_regfile.sv
module npt_regfile #(
   parameter int IDX_W = 4,
   parameter int NIB_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic               wr_hi,
   input  logic [NIB_W-1:0]   wr_nib,
   input  logic [IDX_W-1:0]   rd_idx,
   output logic [2*NIB_W-1:0] rd_byte
);
   localparam int DEPTH = 1 << IDX_W;

   logic [2*NIB_W-1:0] cells [DEPTH];

   genvar gr;
   generate
      for (gr = 0; gr < DEPTH; gr++) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cells[gr] <= '0;
            end else if (we && (wr_idx == IDX_W'(gr))) begin
               if (wr_hi) cells[gr][2*NIB_W-1:NIB_W] <= wr_nib;
               else       cells[gr][NIB_W-1:0]       <= wr_nib;
            end
         end
      end
   endgenerate

   assign rd_byte = cells[rd_idx];
endmodule

// File: rtl/npt_bulk_asm.sv
module npt_bulk_asm #(
   parameter int NIB_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               nib_valid,
   input  logic               nib_hi,
   input  logic [NIB_W-1:0]   nib,
   input  logic               abort,
   output logic               commit,
   output logic [2*NIB_W-1:0] commit_data
);
   logic [NIB_W-1:0] low_q;
   logic             pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_q       <= '0;
         pend_q      <= 1'b0;
         commit      <= 1'b0;
         commit_data <= '0;
      end else begin
         commit <= 1'b0;
         if (abort) begin
            pend_q <= 1'b0;
         end else if (nib_valid) begin
            if (!nib_hi) begin
               low_q  <= nib;
               pend_q <= 1'b1;
            end else if (pend_q) begin
               commit      <= 1'b1;
               commit_data <= {nib, low_q};
               pend_q      <= 1'b0;
            end
         end
      end
   end
endmodule

// File: rtl/npt_read_steer.sv
module npt_read_steer #(
   parameter int ADDR_W      = 5,
   parameter int NIB_W       = 4,
   parameter int BYTE_W      = 8,
   parameter int STATUS_LSB  = 3,
   parameter int MAR_INDEX   = 14,
   parameter bit BUF_READ_EN = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rd_active,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [2*NIB_W-1:0] reg_byte,
   input  logic [2*NIB_W-1:0] buf_byte,
   output logic [BYTE_W-1:0]  status
);
   localparam int IDX_W = ADDR_W - 1;

   logic [2*NIB_W-1:0] src_byte;
   logic [NIB_W-1:0]   pick;

   generate
      if (BUF_READ_EN) begin : g_bufread
         assign src_byte = (addr[IDX_W-1:0] == IDX_W'(MAR_INDEX)) ? buf_byte : reg_byte;
      end else begin : g_regonly
         assign src_byte = reg_byte;
      end
   endgenerate

   assign pick = addr[ADDR_W-1] ? src_byte[2*NIB_W-1:NIB_W] : src_byte[NIB_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         status <= '0;
      else if (rd_active) status <= BYTE_W'(pick) << STATUS_LSB;
      else                status <= '0;
   end
endmodule

// File: rtl/nibble_port_target.sv
module nibble_port_target #(
   parameter int BYTE_W      = 8,
   parameter int ADDR_W      = 5,
   parameter int NIB_W       = 4,
   parameter int SYNC_STAGES = 2,
   parameter int STATUS_LSB  = 3,
   parameter int MAR_INDEX   = 14,
   parameter bit BUF_READ_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [7:0]        host_data,
   input  logic              host_strobe,
   input  logic [7:0]        buf_rd_data,
   output logic [7:0]        host_status,
   output logic              rf_wr_en,
   output logic [3:0]        rf_wr_idx,
   output logic              rf_wr_hi,
   output logic [3:0]        rf_wr_nib,
   output logic              buf_wr_en,
   output logic [7:0]        buf_wr_data
);
   localparam int IDX_W = ADDR_W - 1;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (ADDR_W + 3 > BYTE_W) begin : g_bad_addr
         $error("address field overlaps opcode field");
      end
      if (NIB_W + 1 > ADDR_W) begin : g_bad_nib
         $error("nibble plus tag bit must fit in address field");
      end
      if (STATUS_LSB + NIB_W > BYTE_W) begin : g_bad_status
         $error("status nibble does not fit the status byte");
      end
      if (MAR_INDEX >= (1 << IDX_W)) begin : g_bad_mar
         $error("memory-address slot outside register file");
      end
      if (BYTE_W != 8 || IDX_W != 4 || NIB_W != 4) begin : g_bad_ports
         $error("port widths assume 8-bit bytes and 4-bit nibbles");
      end
   endgenerate

   logic              byte_ev;
   logic              rd_active;
   logic              wr_active;
   logic [ADDR_W-1:0] addr_q;
   logic              bk_valid;
   logic              bk_hi;
   logic [NIB_W-1:0]  bk_nib;
   logic              bk_abort;
   logic [2*NIB_W-1:0] reg_byte;

   npt_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk          (clk),
      .rst_n        (rst_n),
      .strobe_async (host_strobe),
      .event_pulse  (byte_ev)
   );

   npt_cmd_decoder #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W), .NIB_W(NIB_W)) u_dec (
      .clk       (clk),
      .rst_n     (rst_n),
      .ev        (byte_ev),
      .byte_in   (host_data),
      .rd_active (rd_active),
      .wr_active (wr_active),
      .addr_q    (addr_q),
      .rf_we     (rf_wr_en),
      .rf_idx    (rf_wr_idx),
      .rf_hi     (rf_wr_hi),
      .rf_nib    (rf_wr_nib),
      .bk_valid  (bk_valid),
      .bk_hi     (bk_hi),
      .bk_nib    (bk_nib),
      .bk_abort  (bk_abort)
   );

   npt_regfile #(.IDX_W(IDX_W), .NIB_W(NIB_W)) u_rf (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (rf_wr_en),
      .wr_idx  (rf_wr_idx),
      .wr_hi   (rf_wr_hi),
      .wr_nib  (rf_wr_nib),
      .rd_idx  (addr_q[IDX_W-1:0]),
      .rd_byte (reg_byte)
   );

   npt_bulk_asm #(.NIB_W(NIB_W)) u_bulk (
      .clk         (clk),
      .rst_n       (rst_n),
      .nib_valid   (bk_valid),
      .nib_hi      (bk_hi),
      .nib         (bk_nib),
      .abort       (bk_abort),
      .commit      (buf_wr_en),
      .commit_data (buf_wr_data)
   );

   npt_read_steer #(
      .ADDR_W(ADDR_W), .NIB_W(NIB_W), .BYTE_W(BYTE_W),
      .STATUS_LSB(STATUS_LSB), .MAR_INDEX(MAR_INDEX), .BUF_READ_EN(BUF_READ_EN)
   ) u_steer (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_active (rd_active),
      .addr      (addr_q),
      .reg_byte  (reg_byte),
      .buf_byte  (buf_rd_data),
      .status    (host_status)
   );
endmodule

// File: rtl/npt_checker.sv
module npt_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       ev,
   input logic       rd_active,
   input logic       wr_active,
   input logic       rf_wr_en,
   input logic       buf_wr_en,
   input logic [7:0] host_status
);
   // R2: one strobe edge yields a single-cycle event
   assert_event_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ev |=> !ev);

   // R2: register writes only follow a qualified byte event
   assert_write_needs_event_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rf_wr_en |-> $past(ev));

   // R3: register writes only happen in write-address mode
   assert_write_in_wr_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rf_wr_en |-> $past(wr_active));

   // R6: no read address latched means quiet status lines next cycle
   assert_status_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_active |=> (host_status == 8'h00));

   // R8: a commit lasts exactly one cycle
   assert_commit_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      buf_wr_en |=> !buf_wr_en);

   // R11: a read mode never writes registers
   assert_no_write_in_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
      rf_wr_en |-> !$past(rd_active));
endmodule

bind nibble_port_target npt_checker u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ev          (byte_ev),
   .rd_active   (rd_active),
   .wr_active   (wr_active),
   .rf_wr_en    (rf_wr_en),
   .buf_wr_en   (buf_wr_en),
   .host_status (host_status)
);

// File: tb/nibble_port_target_test.sv
module nibble_port_target_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] host_data = 8'h00;
   logic       host_strobe = 1'b0;
   logic [7:0] buf_rd_data = 8'h00;
   logic [7:0] host_status;
   logic       rf_wr_en;
   logic [3:0] rf_wr_idx;
   logic       rf_wr_hi;
   logic [3:0] rf_wr_nib;
   logic       buf_wr_en;
   logic [7:0] buf_wr_data;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [7:0] exp_buf [$];
   logic [8:0] exp_rf  [$];

   always #4 clk = ~clk;

   nibble_port_target uut (
      .clk(clk), .rst_n(rst_n), .host_data(host_data), .host_strobe(host_strobe),
      .buf_rd_data(buf_rd_data), .host_status(host_status),
      .rf_wr_en(rf_wr_en), .rf_wr_idx(rf_wr_idx), .rf_wr_hi(rf_wr_hi), .rf_wr_nib(rf_wr_nib),
      .buf_wr_en(buf_wr_en), .buf_wr_data(buf_wr_data)
   );

   // monitor: pops expected items as results appear
   always @(negedge clk) begin
      if (rst_n && buf_wr_en) begin
         checks++;
         if (exp_buf.size() == 0) begin
            errors++;
            $display("FAIL R8 unexpected commit actual=%h expected=none", buf_wr_data);
         end else begin
            logic [7:0] e;
            e = exp_buf.pop_front();
            if (buf_wr_data !== e) begin
               errors++;
               $display("FAIL R8/R9 commit actual=%h expected=%h", buf_wr_data, e);
            end
         end
      end
      if (rst_n && rf_wr_en) begin
         checks++;
         if (exp_rf.size() == 0) begin
            errors++;
            $display("FAIL R3 unexpected write actual=%h expected=none",
                     {rf_wr_idx, rf_wr_hi, rf_wr_nib});
         end else begin
            logic [8:0] e;
            e = exp_rf.pop_front();
            if ({rf_wr_idx, rf_wr_hi, rf_wr_nib} !== e) begin
               errors++;
               $display("FAIL R3 write actual=%h expected=%h",
                        {rf_wr_idx, rf_wr_hi, rf_wr_nib}, e);
            end
         end
      end
   end

   task automatic send_byte(input logic [7:0] b);
      @(negedge clk);
      host_data   = b;
      host_strobe = 1'b1;
      repeat (4) @(negedge clk);
      host_strobe = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic expect_rf(input logic [3:0] idx, input logic hi, input logic [3:0] nib);
      exp_rf.push_back({idx, hi, nib});
   endtask

   task automatic check_status(input logic [7:0] exp, input string req);
      @(negedge clk);
      checks++;
      if (host_status !== exp) begin
         errors++;
         $display("FAIL %s status actual=%h expected=%h", req, host_status, exp);
      end
   endtask

   task automatic read_nib(input logic [4:0] addr, input logic [3:0] nib, input string req);
      send_byte(8'hE0);
      send_byte({3'b110, addr});
      check_status({1'b0, nib, 3'b000}, req);
      send_byte(8'hE0);
   endtask

   task automatic check_queues(input string req);
      checks++;
      if (exp_buf.size() != 0 || exp_rf.size() != 0) begin
         errors++;
         $display("FAIL %s pending items actual=%0d/%0d expected=0/0",
                  req, exp_buf.size(), exp_rf.size());
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1: reset state
      check_status(8'h00, "R1");
      read_nib(5'h03, 4'h0, "R1");
      read_nib(5'h1C, 4'h0, "R1");

      // R4, R7: full byte 0xA5 into register 6 with repeated phases
      send_byte(8'hE6);
      send_byte(8'h46);
      send_byte(8'h46);
      expect_rf(4'd6, 1'b0, 4'h5); send_byte(8'h05);
      expect_rf(4'd6, 1'b0, 4'h5); send_byte(8'h05);
      expect_rf(4'd6, 1'b1, 4'hA); send_byte(8'h1A);
      send_byte(8'hE0);
      read_nib(5'h06, 4'h5, "R4");
      read_nib(5'h16, 4'hA, "R4");
      check_queues("R7");

      // R3: high-half address writes the upper nibble of register 13
      send_byte(8'h5D);
      expect_rf(4'd13, 1'b1, 4'h3); send_byte(8'h03);
      send_byte(8'hE0);
      read_nib(5'h1D, 4'h3, "R3");
      read_nib(5'h0D, 4'h0, "R3");

      // R11: other opcodes ignored, write mode kept
      send_byte(8'h42);
      send_byte(8'h27);
      send_byte(8'h67);
      send_byte(8'h87);
      send_byte(8'hA7);
      expect_rf(4'd2, 1'b0, 4'h9); send_byte(8'h09);
      send_byte(8'hE0);
      read_nib(5'h02, 4'h9, "R11");
      // R11: data during read writes nothing
      send_byte(8'hC2);
      send_byte(8'h0F);
      check_status({1'b0, 4'h9, 3'b000}, "R11");
      send_byte(8'hE0);
      check_queues("R11");

      // R2: data changes without strobe edges
      send_byte(8'h42);
      @(negedge clk); host_data = 8'h07;
      repeat (6) @(negedge clk); host_data = 8'h1C;
      repeat (6) @(negedge clk);
      send_byte(8'hE0);
      read_nib(5'h02, 4'h9, "R2");
      check_queues("R2");

      // R8, R7: bulk byte, repeated high nibble commits once
      exp_buf.push_back(8'hC3);
      send_byte(8'h03);
      send_byte(8'h1C);
      send_byte(8'h1C);
      check_queues("R7");

      // R9: word 0xBEEF as four nibbles
      exp_buf.push_back(8'hEF);
      exp_buf.push_back(8'hBE);
      send_byte(8'h0F);
      send_byte(8'h1E);
      send_byte(8'h0E);
      send_byte(8'h1B);
      check_queues("R9");

      // R12: end-of-command drops held low nibble
      send_byte(8'h04);
      send_byte(8'hE0);
      send_byte(8'h17);
      check_queues("R12");

      // R10: memory-address slot returns buffer data
      buf_rd_data = 8'h6D;
      read_nib(5'h0E, 4'hD, "R10");
      read_nib(5'h1E, 4'h6, "R10");

      // R6: end-of-command idles decoder, data then goes to bulk
      send_byte(8'hC6);
      check_status({1'b0, 4'h5, 3'b000}, "R5");
      send_byte(8'hE0);
      check_status(8'h00, "R6");
      exp_buf.push_back(8'h82);
      send_byte(8'h02);
      send_byte(8'h18);
      check_queues("R6");
      read_nib(5'h16, 4'hA, "R6");

      repeat (4) @(negedge clk);
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule